// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands and reports their ordering on three flags: A above B, A equal to B, and A below B. Exactly one flag is high at any time. It is purely combinational; no output is registered and there is no pipelining.

The building unit is a slice that compares two 4-bit fields. Each slice also has three relation inputs coming from a less significant slice. When the slice's own fields differ, its own ordering is the answer and the incoming relation plays no part. When its own fields match, the slice passes the incoming relation straight through.

The top level chains slices from the least significant field upward. The least significant slice sees a fixed "equal" relation on its relation inputs. Each higher slice takes the outputs of the slice below it. The outputs of the most significant slice are the result. With the default parameters, two slices form an 8-bit comparator.

Top module: `magcmp_chain`

## Requirements
- R1: For every pair of operands, exactly one of `gt_o`, `eq_o`, `lt_o` is 1. A slice given a one-hot relation input also drives exactly one of its three outputs high.
- R2: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, both read as unsigned 8-bit numbers.
- R3: `eq_o` is 1 exactly when `a_i` equals `b_i`.
- R4: `lt_o` is 1 exactly when `a_i` is less than `b_i`, both read as unsigned 8-bit numbers.
- R5: In a slice whose two 4-bit fields differ, the outputs show the ordering of those fields, whatever the relation inputs are.
- R6: In a slice whose two 4-bit fields are equal, the above output copies the above relation input. The equal output copies the equal input, and the below output copies the below input.
- R7: When bits 7:4 of the operands differ, those bits alone decide the result. When bits 7:4 are equal, the ordering of bits 3:0 decides it. The least significant slice sees the relation (above=0, equal=1, below=0), so equal operands report equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Operand A, unsigned |
| b_i | input | 8 | Operand B, unsigned |
| gt_o | output | 1 | A is greater than B |
| eq_o | output | 1 | A equals B |
| lt_o | output | 1 | A is less than B |

## Verification
The bench builds the top module with its default parameters: two 4-bit slices giving an 8-bit width. At that size all 65,536 operand pairs can be swept, so every case where the upper fields decide and every case where the lower field decides is covered. A separate slice instance is swept over all 256 field pairs under each of the three one-hot relation codes. This covers both forwarding of the relation inputs and the cases where they are ignored.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    localparam rel_t REL_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

    // A local tie defers to the relation carried in from below.
    function automatic rel_t rel_pick(rel_t local_r, rel_t casc_r);
        return local_r.eq ? casc_r : local_r;
    endfunction

endpackage

// File: rtl/magcmp_local.sv
module magcmp_local
    import magcmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output rel_t         rel_o
);
    logic found;

    // The most significant differing bit decides the ordering.
    always_comb begin
        rel_o = REL_EQUAL;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && (a_i[i] != b_i[i])) begin
                found    = 1'b1;
                rel_o.gt = a_i[i];
                rel_o.lt = b_i[i];
                rel_o.eq = 1'b0;
            end
        end
    end
endmodule

// File: rtl/magcmp_merge.sv
module magcmp_merge
    import magcmp_pkg::*;
(
    input  rel_t local_i,
    input  rel_t casc_i,
    output rel_t rel_o
);
    assign rel_o = rel_pick(local_i, casc_i);
endmodule

// File: rtl/magcmp_slice.sv
module magcmp_slice
    import magcmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_gt_i,
    input  logic         cin_eq_i,
    input  logic         cin_lt_i,
    output logic         gt_o,
    output logic         eq_o,
    output logic         lt_o
);
    rel_t local_rel;
    rel_t casc_rel;
    rel_t out_rel;

    assign casc_rel = '{gt: cin_gt_i, eq: cin_eq_i, lt: cin_lt_i};

    magcmp_local #(.W(W)) local_i (
        .a_i   (a_i),
        .b_i   (b_i),
        .rel_o (local_rel)
    );

    magcmp_merge merge_i (
        .local_i (local_rel),
        .casc_i  (casc_rel),
        .rel_o   (out_rel)
    );

    assign gt_o = out_rel.gt;
    assign eq_o = out_rel.eq;
    assign lt_o = out_rel.lt;
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int SLICE_W  = 4,
    parameter int N_SLICES = 2
) (
    input  logic [SLICE_W*N_SLICES-1:0] a_i,
    input  logic [SLICE_W*N_SLICES-1:0] b_i,
    output logic                        gt_o,
    output logic                        eq_o,
    output logic                        lt_o
);
    localparam int TOTAL_W = SLICE_W * N_SLICES;

    // Relation links: index 0 feeds the least significant slice.
    logic [N_SLICES:0] lnk_gt;
    logic [N_SLICES:0] lnk_eq;
    logic [N_SLICES:0] lnk_lt;

    assign lnk_gt[0] = REL_EQUAL.gt;
    assign lnk_eq[0] = REL_EQUAL.eq;
    assign lnk_lt[0] = REL_EQUAL.lt;

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        magcmp_slice #(.W(SLICE_W)) slice_i (
            .a_i      (a_i[s*SLICE_W +: SLICE_W]),
            .b_i      (b_i[s*SLICE_W +: SLICE_W]),
            .cin_gt_i (lnk_gt[s]),
            .cin_eq_i (lnk_eq[s]),
            .cin_lt_i (lnk_lt[s]),
            .gt_o     (lnk_gt[s+1]),
            .eq_o     (lnk_eq[s+1]),
            .lt_o     (lnk_lt[s+1])
        );
    end

    assign gt_o = lnk_gt[N_SLICES];
    assign eq_o = lnk_eq[N_SLICES];
    assign lt_o = lnk_lt[N_SLICES];

    if (TOTAL_W < 1) begin : g_bad_width
        initial $error("magcmp_chain: width must be positive");
    end
endmodule

// File: rtl/magcmp_chain_chk.sv
module magcmp_chain_chk #(
    parameter int SLICE_W  = 4,
    parameter int N_SLICES = 2
) (
    input logic [SLICE_W*N_SLICES-1:0] a_i,
    input logic [SLICE_W*N_SLICES-1:0] b_i,
    input logic                        gt_o,
    input logic                        eq_o,
    input logic                        lt_o
);
    localparam int WIDTH = SLICE_W * N_SLICES;

    logic [SLICE_W-1:0] a_top;
    logic [SLICE_W-1:0] b_top;

    assign a_top = a_i[WIDTH-1 -: SLICE_W];
    assign b_top = b_i[WIDTH-1 -: SLICE_W];

    always_comb begin
        p_onehot_r1: assert ($onehot({gt_o, eq_o, lt_o}))
            else $error("R1: flags not one-hot");
        p_gt_r2: assert (gt_o == (a_i > b_i))
            else $error("R2: greater flag wrong");
        p_eq_r3: assert (eq_o == (a_i == b_i))
            else $error("R3: equal flag wrong");
        p_lt_r4: assert (lt_o == (a_i < b_i))
            else $error("R4: less flag wrong");
        if (a_top != b_top) begin
            p_upper_decides_r7: assert (gt_o == (a_top > b_top))
                else $error("R7: upper field did not decide");
        end
    end
endmodule

bind magcmp_chain magcmp_chain_chk #(
    .SLICE_W  (SLICE_W),
    .N_SLICES (N_SLICES)
) chk_i (
    .a_i  (a_i),
    .b_i  (b_i),
    .gt_o (gt_o),
    .eq_o (eq_o),
    .lt_o (lt_o)
);

// File: tb/magcmp_chain_tb_top.sv
`timescale 1ns/1ps
module magcmp_chain_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [7:0] a, b;
    logic       gt, eq, lt;
    logic [3:0] sa, sb;
    logic       cg, ce, cl;
    logic       sgt, seq, slt;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    magcmp_chain dut_i (
        .a_i (a), .b_i (b), .gt_o (gt), .eq_o (eq), .lt_o (lt)
    );

    magcmp_slice #(.W(4)) slice_i (
        .a_i (sa), .b_i (sb),
        .cin_gt_i (cg), .cin_eq_i (ce), .cin_lt_i (cl),
        .gt_o (sgt), .eq_o (seq), .lt_o (slt)
    );

    task automatic check3(string req, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d sa=%0d sb=%0d got=%b expected=%b",
                     req, a, b, sa, sb, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; sa = '0; sb = '0; cg = 1'b0; ce = 1'b1; cl = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset-state check, R3/R7: zero operands report equal
        check3("R3 idle equal", {gt, eq, lt}, 3'b010);

        // Full sweep of the 8-bit top: R1 R2 R3 R4 R7
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                @(posedge clk);
                a = ia[7:0];
                b = ib[7:0];
                @(negedge clk);
                check3("R1 onehot", {1'b0, 1'b0, ($countones({gt, eq, lt}) == 1)}, 3'b001);
                check3("R2 R3 R4 relation", {gt, eq, lt},
                       {ia > ib, ia == ib, ia < ib});
                if (ia[7:4] != ib[7:4])
                    check3("R7 upper decides", {gt, eq, lt},
                           {ia[7:4] > ib[7:4], 1'b0, ia[7:4] < ib[7:4]});
                else
                    check3("R7 lower decides", {gt, eq, lt},
                           {ia[3:0] > ib[3:0], ia[3:0] == ib[3:0], ia[3:0] < ib[3:0]});
            end
        end

        // Slice sweep under each one-hot relation code: R1 R5 R6
        for (int code = 0; code < 3; code++) begin
            for (int ia = 0; ia < 16; ia++) begin
                for (int ib = 0; ib < 16; ib++) begin
                    logic [2:0] cin;
                    cin = 3'b100 >> code;
                    @(posedge clk);
                    sa = ia[3:0];
                    sb = ib[3:0];
                    {cg, ce, cl} = cin;
                    @(negedge clk);
                    check3("R1 slice onehot",
                           {1'b0, 1'b0, ($countones({sgt, seq, slt}) == 1)}, 3'b001);
                    if (ia != ib)
                        check3("R5 local decides", {sgt, seq, slt},
                               {ia > ib, 1'b0, ia < ib});
                    else
                        check3("R6 forward relation", {sgt, seq, slt}, cin);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule